// File: doc/BRIEF.md
# Subword-Sliced Left Rotator

This block rotates an 18-bit word left by one bit position on a datapath made of three 6-bit slices: left (bits 17:12), middle (bits 11:6) and right (bits 5:0). A slice may only reorder the bits inside its own subword. Bits move from one subword to another only through a fixed transposition, which is wiring alone and is its own inverse. A full rotate takes three steps. First, every subword rotates left locally. Second, the word is transposed and only the right subword gets a fixed permutation. Third, transposing again gives the rotated word.

The block can run in two modes. In the pipelined mode, three slice layers sit in series with the transposition wiring into and out of the middle layer. One word can be issued every cycle, and each result appears four cycles after its issue. In the stepped mode, one shared slice layer is used twice with the transposition in its loop. Each slice operation takes one cycle, so a result appears two cycles after issue. The stepped mode holds only one word at a time.

Top module: `rxp_rotator_top`

## Requirements
- R1: While `rst_n` is low, and after reset until the first result, `out_valid` is 0 and `out_data` is all zeros.
- R2: With `mode_pipe`=1 at an edge where `in_valid` is 1, `out_valid` is 1 exactly four clock edges later. In that cycle `out_data` equals the input word rotated left by one: bit i goes to bit i+1, and bit 17 goes to bit 0.
- R3: In pipelined mode a new word is accepted on every edge. Back-to-back words give back-to-back results, in issue order.
- R4: With `mode_pipe`=0, a word accepted while the stepper is idle produces `out_valid`=1 two edges later, carrying its left rotation by one.
- R5: In stepped mode, `in_valid` on the edge right after an accepted word is ignored. It produces no result, and the next accepted word can arrive one edge later.
- R6: `out_data` is all zeros in every cycle in which `out_valid` is 0.
- R7: The rotate is built from subword-local rotation, transposition and a right-subword permutation. In the transposition, output subword p, slot s (2-bit slots, slot 2 = bits 5:4 of a subword) takes pair p of input subword s. Between the two transpositions, only the right subword changes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_pipe | input | 1 | 1 = three-layer pipelined mode, 0 = stepped mode; sampled with `in_valid` |
| in_valid | input | 1 | Input word present this cycle |
| in_data | input | 18 | Word to rotate; bit 17 is the leftmost bit |
| out_valid | output | 1 | Result present this cycle |
| out_data | output | 18 | Rotated word, zero when `out_valid` is 0 |

## Verification
The assertions check the following on every cycle:
- the fixed latency and correct rotation of each pipelined and stepped issue;
- that the stepper holds a word for exactly one extra cycle;
- that a valid input arriving while the stepper is busy leaves no trace at the output;
- that the middle layer changes nothing outside the right subword.

Some properties are only shown by the bench scenarios:
- ordering across long back-to-back pipelined streams;
- the drained switch between modes;
- the idle-output zeroing across walking-one, all-ones and random words.

// File: rtl/rxp_pkg.sv
package rxp_pkg;
  localparam int SUB_W    = 6;
  localparam int N_SUB    = 3;
  localparam int PAIR_W   = 2;
  localparam int WORD_W   = SUB_W * N_SUB;
  localparam int N_LAYER  = 3;
  localparam int PIPE_LAT = N_LAYER + 1;
  localparam int STEP_LAT = 2;

  typedef logic [WORD_W-1:0] word_t;
  typedef logic [SUB_W-1:0]  sub_t;

  typedef enum logic [1:0] {
    OP_PASS       = 2'd0,
    OP_ROT_ALL    = 2'd1,
    OP_PERM_RIGHT = 2'd2
  } slice_op_e;

  // local left rotate inside one subword
  function automatic sub_t sub_rotl(sub_t x);
    return {x[SUB_W-2:0], x[SUB_W-1]};
  endfunction

  // fixed reorder of the right subword while in transposed form
  function automatic sub_t right_perm(sub_t x);
    sub_t y;
    y[5] = x[5];
    y[4] = x[2];
    y[3] = x[3];
    y[2] = x[0];
    y[1] = x[1];
    y[0] = x[4];
    return y;
  endfunction

  // one slice: what a single subword does for a given operation
  function automatic sub_t slice_sub(sub_t x, slice_op_e op, logic is_right);
    case (op)
      OP_ROT_ALL:    return sub_rotl(x);
      OP_PERM_RIGHT: return is_right ? right_perm(x) : x;
      default:       return x;
    endcase
  endfunction

  // pair-wise transposition: out subword p, slot s <- in subword s, pair p
  function automatic word_t xpose(word_t w);
    word_t y;
    for (int p = 0; p < N_SUB; p++)
      for (int s = 0; s < N_SUB; s++)
        y[p*SUB_W + s*PAIR_W +: PAIR_W] = w[s*SUB_W + p*PAIR_W +: PAIR_W];
    return y;
  endfunction

  function automatic slice_op_e layer_op(int k);
    if (k == 0) return OP_ROT_ALL;
    if (k == 1) return OP_PERM_RIGHT;
    return OP_PASS;
  endfunction

  // direct whole-word rotate, used only as the assertion oracle
  function automatic word_t word_rotl1(word_t w);
    return {w[WORD_W-2:0], w[WORD_W-1]};
  endfunction
endpackage

// File: rtl/rxp_slice_layer.sv
module rxp_slice_layer
  import rxp_pkg::*;
(
  input  word_t     din,
  input  slice_op_e op,
  output word_t     dout
);
  for (genvar k = 0; k < N_SUB; k++) begin : g_sub
    assign dout[k*SUB_W +: SUB_W] = slice_sub(din[k*SUB_W +: SUB_W], op, (k == 0));
  end
endmodule

// File: rtl/rxp_pipe.sv
module rxp_pipe
  import rxp_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  in_valid,
  input  word_t in_data,
  output logic  out_valid,
  output word_t out_data
);
  word_t lay_i  [N_LAYER];
  word_t lay_o  [N_LAYER];
  word_t stg_nx [PIPE_LAT];
  word_t stg_d  [PIPE_LAT];
  logic [PIPE_LAT-1:0] stg_v;

  for (genvar k = 0; k < N_LAYER; k++) begin : g_layer
    if (k == 0) begin : g_first
      assign lay_i[k] = in_data;
    end else begin : g_next
      assign lay_i[k] = stg_d[k-1];
    end
    rxp_slice_layer u_lay (.din(lay_i[k]), .op(layer_op(k)), .dout(lay_o[k]));
    if (k < N_LAYER - 1) begin : g_x
      assign stg_nx[k] = xpose(lay_o[k]);
    end else begin : g_nx
      assign stg_nx[k] = lay_o[k];
    end
  end
  assign stg_nx[PIPE_LAT-1] = stg_d[PIPE_LAT-2];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stg_v <= '0;
      for (int i = 0; i < PIPE_LAT; i++) stg_d[i] <= '0;
    end else begin
      stg_v <= {stg_v[PIPE_LAT-2:0], in_valid};
      for (int i = 0; i < PIPE_LAT; i++) stg_d[i] <= stg_nx[i];
    end
  end

  assign out_valid = stg_v[PIPE_LAT-1];
  assign out_data  = stg_d[PIPE_LAT-1];

  word_t mid_back;
  assign mid_back = xpose(stg_d[1]);

  // R2 R3
  pipe_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |-> ##4 (out_valid && out_data == word_rotl1($past(in_data, 4))));
  // R7
  mid_layer_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stg_v[1] |-> (mid_back[WORD_W-1:SUB_W] == $past(stg_d[0][WORD_W-1:SUB_W])));
endmodule

// File: rtl/rxp_stepper.sv
module rxp_stepper
  import rxp_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  in_valid,
  input  word_t in_data,
  output logic  out_valid,
  output word_t out_data
);
  logic      busy;
  logic      accept;
  word_t     work;
  word_t     sl_in;
  word_t     sl_out;
  word_t     loop_x;
  slice_op_e sl_op;

  assign accept = in_valid && !busy;
  assign sl_in  = busy ? work : in_data;
  assign sl_op  = busy ? OP_PERM_RIGHT : OP_ROT_ALL;

  rxp_slice_layer u_shared (.din(sl_in), .op(sl_op), .dout(sl_out));
  assign loop_x = xpose(sl_out);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy      <= 1'b0;
      work      <= '0;
      out_valid <= 1'b0;
      out_data  <= '0;
    end else begin
      out_valid <= 1'b0;
      if (accept) begin
        work <= loop_x;
        busy <= 1'b1;
      end else if (busy) begin
        out_data  <= loop_x;
        out_valid <= 1'b1;
        busy      <= 1'b0;
      end
    end
  end

  // R4
  step_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
    accept |-> ##2 (out_valid && out_data == word_rotl1($past(in_data, 2))));
  // R5
  step_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> !busy);
  // R5
  step_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && in_valid) |=> ##1 !out_valid);
endmodule

// File: rtl/rxp_rotator_top.sv
module rxp_rotator_top
  import rxp_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mode_pipe,
  input  logic              in_valid,
  input  logic [WORD_W-1:0] in_data,
  output logic              out_valid,
  output logic [WORD_W-1:0] out_data
);
  logic  pipe_iv, step_iv, pipe_ov, step_ov;
  word_t pipe_od, step_od;

  assign pipe_iv = in_valid && mode_pipe;
  assign step_iv = in_valid && !mode_pipe;

  rxp_pipe u_pipe (
    .clk(clk), .rst_n(rst_n), .in_valid(pipe_iv), .in_data(in_data),
    .out_valid(pipe_ov), .out_data(pipe_od)
  );

  rxp_stepper u_step (
    .clk(clk), .rst_n(rst_n), .in_valid(step_iv), .in_data(in_data),
    .out_valid(step_ov), .out_data(step_od)
  );

  assign out_valid = pipe_ov || step_ov;
  assign out_data  = pipe_ov ? pipe_od : (step_ov ? step_od : '0);

  // R6
  idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> (out_data == '0));
  // R1
  reset_quiet_chk: assert property (@(posedge clk)
    $past(!rst_n) |-> !out_valid);
endmodule

// File: tb/rxp_rotator_top_test.sv
module rxp_rotator_top_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        mode_pipe = 1'b1;
  logic        in_valid = 1'b0;
  logic [17:0] in_data = '0;
  logic        out_valid;
  logic [17:0] out_data;

  int n_chk = 0;
  int n_bad = 0;
  int cyc = 0;
  int step_busy_to = -1;
  int          due_q[$];
  logic [17:0] dat_q[$];
  bit          src_q[$];

  always #10 clk = ~clk;

  rxp_rotator_top uut (
    .clk(clk), .rst_n(rst_n), .mode_pipe(mode_pipe), .in_valid(in_valid),
    .in_data(in_data), .out_valid(out_valid), .out_data(out_data)
  );

  function automatic logic [17:0] ref_rotl(input logic [17:0] x);
    logic [17:0] r;
    for (int i = 0; i < 18; i++) r[(i + 1) % 18] = x[i];
    return r;
  endfunction

  // reference model: queue of expected results with their due cycle
  always @(posedge clk) begin
    cyc = cyc + 1;
    if (rst_n && in_valid) begin
      if (mode_pipe) begin
        due_q.push_back(cyc + 3); dat_q.push_back(ref_rotl(in_data)); src_q.push_back(1'b1);
      end else if (cyc > step_busy_to) begin
        due_q.push_back(cyc + 1); dat_q.push_back(ref_rotl(in_data)); src_q.push_back(1'b0);
        step_busy_to = cyc + 1;
      end
    end
  end

  // compare every cycle away from the active edge
  always @(negedge clk) begin
    logic        ev;
    logic [17:0] ed;
    string       tag;
    ev = 1'b0; ed = '0;
    if (!rst_n) tag = "R1";
    else tag = "R5 R6";
    if (due_q.size() > 0 && due_q[0] == cyc) begin
      ev = 1'b1; ed = dat_q[0];
      tag = src_q[0] ? "R2 R3 R7" : "R4 R7";
      void'(due_q.pop_front()); void'(dat_q.pop_front()); void'(src_q.pop_front());
    end
    n_chk++;
    if (out_valid !== ev || out_data !== ed) begin
      n_bad++;
      $display("FAIL %s cycle %0d: valid=%b data=%h expected valid=%b data=%h",
               tag, cyc, out_valid, out_data, ev, ed);
    end
  end

  task automatic drive(input bit m, input bit v, input logic [17:0] d);
    @(negedge clk);
    mode_pipe = m; in_valid = v; in_data = d;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) drive(mode_pipe, 1'b0, '0);
  endtask

  task automatic report;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    #(20 * 150000);
    n_bad++;
    $display("FAIL watchdog: run did not finish, expected completion");
    report();
  end

  initial begin
    // R1: reset held, outputs quiet
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    idle(3);
    // R2 R3: walking one, back to back, pipelined
    for (int i = 0; i < 18; i++) drive(1'b1, 1'b1, 18'(1) << i);
    drive(1'b1, 1'b1, 18'h3FFFF);
    drive(1'b1, 1'b1, 18'h20001);
    drive(1'b1, 1'b1, 18'h00000);
    idle(6);
    // R2 R6: random words with gaps
    for (int i = 0; i < 60; i++) drive(1'b1, ($urandom % 10) < 7, 18'($urandom));
    idle(6);
    // R4 R5: stepped walking one, valid held two cycles (second ignored)
    for (int i = 0; i < 18; i++) begin
      drive(1'b0, 1'b1, 18'(1) << i);
      drive(1'b0, 1'b1, 18'h2AAAA);
      idle(1);
    end
    idle(4);
    // R5: continuous valid, only every other word taken
    for (int i = 0; i < 30; i++) drive(1'b0, 1'b1, 18'($urandom));
    idle(4);
    // R4: stepped random with gaps and corner words
    for (int i = 0; i < 40; i++) drive(1'b0, ($urandom % 2) == 1, 18'($urandom));
    drive(1'b0, 1'b1, 18'h20000);
    idle(2);
    drive(1'b0, 1'b1, 18'h3FFFF);
    idle(6);
    // R3: pipelined again after a drained switch
    for (int i = 0; i < 25; i++) drive(1'b1, 1'b1, 18'($urandom));
    idle(8);
    if (due_q.size() != 0) begin
      n_bad++;
      $display("FAIL R2 R4: %0d results missing, expected 0", due_q.size());
    end
    report();
  end
endmodule